// File: doc/BRIEF.md
# Generic Peripheral Clock Generator

This block produces one general-purpose clock for peripherals that need a frequency of their own. It selects one of four free-running source clocks: two oscillators and two PLL outputs. It can divide the selected clock by an even ratio from 2 to 512, or pass it through unchanged. The result is gated by a software enable and by a sleep request.

Software drives a small control word made of an enable bit, a pair-select bit, an index bit, a divide-enable bit and an 8-bit divide value. The sleep controller drives a request line that stops the clock while peripheral clocks are off. The enable and the sleep request are resynchronised into the selected source domain. They are applied only while the generated clock is low, so every high pulse has its full width. The source must only be changed while the block is disabled and the output has settled low.

Top module: `gclk_gen`

## Requirements
- R1: The source index is {cfg_pll_sel, cfg_src_idx}. Value 0 selects clk_osc0, 1 selects clk_osc1, 2 selects clk_pll0 and 3 selects clk_pll1.
- R2: With cfg_div_en = 1, gclk_out has a period of 2*(cfg_div+1) source periods and a high phase of exactly half that. This holds at cfg_div = 0 (ratio 2) and at cfg_div = 255 (ratio 512).
- R3: With cfg_div_en = 0, gclk_out has the period of the selected source and a high phase of half a source period.
- R4: A new cfg_div value written during a high phase does not shorten or stretch that phase. It governs every half-period that starts from the next toggle onward.
- R5: Some time after cfg_en falls, gclk_out is low and makes no rising edge.
- R6: While sleep_req = 1, gclk_out is low and makes no rising edge, whatever the value of cfg_en. After sleep_req returns to 0, the configured period resumes.
- R7: While rst_n = 0 and the sources run, gclk_out stays low.
- R8: When cfg_en falls during a high phase of the divided clock, that high phase still lasts its full (cfg_div+1) source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, sampled by the selected source clock |
| clk_osc0 | input | 1 | Source clock, oscillator 0 |
| clk_osc1 | input | 1 | Source clock, oscillator 1 |
| clk_pll0 | input | 1 | Source clock, PLL 0 |
| clk_pll1 | input | 1 | Source clock, PLL 1 |
| cfg_en | input | 1 | Software clock enable |
| cfg_pll_sel | input | 1 | 0 selects the oscillator pair, 1 selects the PLL pair |
| cfg_src_idx | input | 1 | Member 0 or 1 of the chosen pair |
| cfg_div_en | input | 1 | 1 divides the selected source, 0 bypasses the divider |
| cfg_div | input | 8 | Divide value; the ratio is 2*(cfg_div+1) |
| sleep_req | input | 1 | 1 while peripheral clocks are stopped for sleep |
| gclk_out | output | 1 | Gated, optionally divided clock |

## Verification
The hardest situations to reach are the ones where a control input changes inside a running half-period. One case is a divide value rewritten while the clock is high. The other is the enable dropping while the clock is high. From the ports these only happen when the stimulus lines up with an output edge. The bench therefore waits for a rising edge of gclk_out and changes cfg_div or cfg_en one nanosecond later. It then times the following falling and rising edges against the old and new ratios. Random configurations of source, bypass and divide value are added around these directed cases, including the extreme ratios 2 and 512.

// File: rtl/gclk_pkg.sv
// Shared definitions for the generic clock generator.
// Assumes exactly four sources, indexed {pair select, member index}.
package gclk_pkg;
    localparam int unsigned N_SRC   = 4;
    localparam int unsigned SRC_W   = $clog2(N_SRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_OSC0 = 2'd0,
        SRC_OSC1 = 2'd1,
        SRC_PLL0 = 2'd2,
        SRC_PLL1 = 2'd3
    } src_e;
endpackage

// File: rtl/gclk_src_mux.sv
// Source selector: routes one of N_SRC clocks to its output.
// Assumes the selection only changes while all downstream logic is idle
// (enable low, output settled low); it is not a glitch-free switch.
module gclk_src_mux #(
    parameter int unsigned N_SRC = gclk_pkg::N_SRC,
    localparam int unsigned SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] clk_src,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_o
);
    // Purpose: plain indexed selection of the source clock.
    always_comb begin
        clk_o = clk_src[sel];
    end
endmodule

// File: rtl/gclk_sync.sv
// Level synchronizer: brings an asynchronous control level into the
// clk domain through STAGES flops. Synchronous active-low reset to 0.
module gclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: one stage of the resynchronising shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gclk_divider.sv
// Even divider: toggles its output every (limit+1) clk cycles, so the
// ratio is 2*(div_val+1) with 50% duty. The limit is reloaded only at a
// toggle or while idle. When run drops, the divider finishes the current
// high phase and then parks low. Synchronous active-low reset.
module gclk_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             idle;
    logic             wrap;

    assign idle = !run && !div_o;
    assign wrap = (cnt == lim);

    // Purpose: half-period counter, output toggle and limit reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            lim   <= '0;
            div_o <= 1'b0;
        end else if (idle) begin
            cnt   <= '0;
            lim   <= div_val;
            div_o <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            lim   <= div_val;
            div_o <= !div_o;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R2: the counter never runs past the limit of its half-period.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);

    // R2: the output only toggles at the end of a full half-period.
    p_toggle_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> $past(cnt == lim));

    // R4: the limit is only reloaded at a toggle or while parked.
    p_lim_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lim) |-> $past((cnt == lim) || (!run && !div_o)));

    // R5: once parked low with no run request, the output stays low.
    p_park_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !div_o) |=> !div_o);
endmodule

// File: rtl/gclk_gate.sv
// Clock gate for the bypass path: the enable is captured on the falling
// edge, so it only changes while clk is low and every high phase is full.
// Synchronous (to the falling edge) active-low reset.
module gclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_o
);
    logic gate_q;

    // Purpose: capture the enable while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= run;
        end
    end

    assign clk_o = clk & gate_q;
endmodule

// File: rtl/gclk_gen.sv
// Generic clock generator top: source select, resynchronised enable and
// sleep mask, even divider with bypass. Assumes the source selection and
// cfg_div_en change only while cfg_en is low and gclk_out has settled low.
module gclk_gen #(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             rst_n,
    input  logic             clk_osc0,
    input  logic             clk_osc1,
    input  logic             clk_pll0,
    input  logic             clk_pll1,
    input  logic             cfg_en,
    input  logic             cfg_pll_sel,
    input  logic             cfg_src_idx,
    input  logic             cfg_div_en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             sleep_req,
    output logic             gclk_out
);
    import gclk_pkg::*;

    logic [N_SRC-1:0] src_vec;
    src_e             src_sel;
    logic             clk_sel;
    logic             run_raw;
    logic             run_s;
    logic             div_clk;
    logic             byp_clk;

    assign src_vec = {clk_pll1, clk_pll0, clk_osc1, clk_osc0};
    assign src_sel = src_e'({cfg_pll_sel, cfg_src_idx});
    assign run_raw = cfg_en & ~sleep_req;

    gclk_src_mux #(.N_SRC(N_SRC)) u_mux (
        .clk_src (src_vec),
        .sel     (src_sel),
        .clk_o   (clk_sel)
    );

    gclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_sel),
        .rst_n (rst_n),
        .d     (run_raw),
        .q     (run_s)
    );

    gclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk_sel),
        .rst_n   (rst_n),
        .run     (run_s),
        .div_val (cfg_div),
        .div_o   (div_clk)
    );

    gclk_gate u_gate (
        .clk   (clk_sel),
        .rst_n (rst_n),
        .run   (run_s),
        .clk_o (byp_clk)
    );

    // Purpose: choose the divided or the gated undivided clock.
    always_comb begin
        gclk_out = cfg_div_en ? div_clk : byp_clk;
    end
endmodule

// File: tb/tb_gclk_gen.sv
`timescale 1ns/1ps
module tb_gclk_gen;
    logic       rst_n = 1'b0;
    logic       clk_osc0 = 1'b0, clk_osc1 = 1'b0, clk_pll0 = 1'b0, clk_pll1 = 1'b0;
    logic       cfg_en = 1'b0, cfg_pll_sel = 1'b0, cfg_src_idx = 1'b0, cfg_div_en = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       sleep_req = 1'b0;
    logic       gclk_out;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;
    int cyc = 0;
    int cur_div = 0;

    // osc0 doubles as the 125 MHz bench clock
    always #4 clk_osc0 = ~clk_osc0;
    always #5 clk_osc1 = ~clk_osc1;
    always #3 clk_pll0 = ~clk_pll0;
    always #7 clk_pll1 = ~clk_pll1;

    gclk_gen dut (
        .rst_n(rst_n), .clk_osc0(clk_osc0), .clk_osc1(clk_osc1),
        .clk_pll0(clk_pll0), .clk_pll1(clk_pll1), .cfg_en(cfg_en),
        .cfg_pll_sel(cfg_pll_sel), .cfg_src_idx(cfg_src_idx),
        .cfg_div_en(cfg_div_en), .cfg_div(cfg_div), .sleep_req(sleep_req),
        .gclk_out(gclk_out)
    );

    always @(posedge gclk_out) edges++;

    always @(posedge clk_osc0) begin
        cyc++;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, act=%0d exp<%0d cycles", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    function automatic real src_period(int s);
        case (s)
            0: return 8.0;
            1: return 10.0;
            2: return 6.0;
            default: return 14.0;
        endcase
    endfunction

    function automatic real exp_period(int s, bit den, int d);
        return den ? 2.0 * (d + 1) * src_period(s) : src_period(s);
    endfunction

    function automatic real exp_high(int s, bit den, int d);
        return exp_period(s, den, d) / 2.0;
    endfunction

    task automatic chk(bit ok, string req, string what, real act, real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0.3f exp=%0.3f", req, what, act, exp);
        end
    endtask

    function automatic bit near(real a, real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // Output must be low with no rising edge over a window.
    task automatic chk_quiet(string req, string what);
        int e0;
        e0 = edges;
        #300;
        chk(edges == e0 && gclk_out == 1'b0, req, what, real'(edges - e0), 0.0);
    endtask

    // Disable, drain, confirm quiet, then apply a new configuration and enable.
    task automatic configure(int s, bit den, int d, string req);
        cfg_en = 1'b0;
        #((2 * (cur_div + 1) + 12) * 14);
        chk_quiet(req, "low before source change");
        {cfg_pll_sel, cfg_src_idx} = s[1:0];
        cfg_div_en = den;
        cfg_div = d[7:0];
        cur_div = d;
        #20;
        cfg_en = 1'b1;
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge gclk_out);
        @(posedge gclk_out);
        t0 = $realtime;
        @(negedge gclk_out);
        t1 = $realtime;
        @(posedge gclk_out);
        t2 = $realtime;
        per = t2 - t0;
        hi = t1 - t0;
    endtask

    task automatic run_cfg(int s, bit den, int d, string req);
        real per, hi;
        configure(s, den, d, req);
        measure(per, hi);
        chk(near(per, exp_period(s, den, d)), req, $sformatf("period src=%0d den=%0d div=%0d", s, den, d),
            per, exp_period(s, den, d));
        chk(near(hi, exp_high(s, den, d)), req, $sformatf("high src=%0d den=%0d div=%0d", s, den, d),
            hi, exp_high(s, den, d));
    endtask

    initial begin
        int unsigned seed_init;
        real t0, t1, t2, per, hi;
        seed_init = $urandom(32'h5eed_0042);

        // R7: enabled bypass config held in reset must stay low
        cfg_en = 1'b1;
        cfg_pll_sel = 1'b1;
        cfg_src_idx = 1'b1;
        #400;
        chk_quiet("R7", "output during reset");
        rst_n = 1'b1;
        #100;

        // R1 / R3: bypass on each source identifies the selection
        for (int s = 0; s < 4; s++) run_cfg(s, 1'b0, 0, "R1 R3");
        // R1 / R2: divided, small ratios on each source
        for (int s = 0; s < 4; s++) run_cfg(s, 1'b1, 3, "R1 R2");
        // R2: extreme ratios 2 and 512
        run_cfg(2, 1'b1, 0, "R2");
        run_cfg(0, 1'b1, 255, "R2");

        // R5: enable off leaves the output parked low
        run_cfg(1, 1'b1, 2, "R2");
        cfg_en = 1'b0;
        #((2 * 3 + 12) * 14);
        chk_quiet("R5", "divided output after disable");
        run_cfg(3, 1'b0, 0, "R3");
        cfg_en = 1'b0;
        #200;
        chk_quiet("R5", "bypass output after disable");

        // R6: sleep mask wins over enable, then the clock resumes
        run_cfg(1, 1'b1, 2, "R6");
        sleep_req = 1'b1;
        #((2 * 3 + 12) * 14);
        chk_quiet("R6", "divided output during sleep");
        sleep_req = 1'b0;
        measure(per, hi);
        chk(near(per, 60.0), "R6", "period after wake", per, 60.0);
        run_cfg(2, 1'b0, 0, "R6");
        sleep_req = 1'b1;
        #200;
        chk_quiet("R6", "bypass output during sleep");
        sleep_req = 1'b0;
        measure(per, hi);
        chk(near(per, 6.0), "R6", "bypass period after wake", per, 6.0);

        // R4: divide value rewritten during a high phase
        run_cfg(0, 1'b1, 4, "R4");
        @(posedge gclk_out);
        t0 = $realtime;
        #1 cfg_div = 8'd9;
        cur_div = 9;
        @(negedge gclk_out);
        t1 = $realtime;
        @(posedge gclk_out);
        t2 = $realtime;
        chk(near(t1 - t0, 40.0), "R4", "high phase keeps old ratio", t1 - t0, 40.0);
        chk(near(t2 - t1, 80.0), "R4", "next phase uses new ratio", t2 - t1, 80.0);

        // R8: disable during a high phase keeps the full pulse
        run_cfg(3, 1'b1, 5, "R8");
        @(posedge gclk_out);
        t0 = $realtime;
        #1 cfg_en = 1'b0;
        @(negedge gclk_out);
        t1 = $realtime;
        chk(near(t1 - t0, 84.0), "R8", "last high pulse width", t1 - t0, 84.0);
        chk_quiet("R8", "quiet after final pulse");

        // Random configurations: R1 R2 R3
        for (int i = 0; i < 14; i++) begin
            int s, d;
            bit den;
            s = int'($urandom_range(3, 0));
            den = 1'($urandom_range(1, 0));
            d = int'($urandom_range(63, 0));
            run_cfg(s, den, d, den ? "R1 R2" : "R1 R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule